// File: doc/BRIEF.md
# Command-Driven Streaming Sequencer Controller

This block is the top-level control state machine of an image-capture pipeline. A host talks to it through a small synchronous register port. The host writes a command code to ask for streaming, a halt, a test-pattern mode or a return to idle. The controller takes the command and moves to the requested state. It then waits a programmable number of settling cycles. After that it clears the command register back to zero, so the host can poll that register to see that the command has finished. A separate read-only register, also driven onto a port, shows the current sequencer state.

Two registered enable strobes gate the rest of the pipeline. Configuration updates are allowed only while the pipeline is halted. Automatic-algorithm updates are allowed while halted or streaming. In idle and in test-pattern mode both enables are low, and the host has full manual control. An unknown command code is dropped at once and raises a sticky error flag.

Top module: `stream_seq_ctrl`

## Requirements
- R1: After reset the state is idle (encoding 0), the command register reads 0, the settle register reads SETTLE_RESET (default 4), and config_apply_en, algo_update_en and cmd_error are all low.
- R2: State encoding is idle=0, stopped=1, streaming=2, test-pattern=3. Command codes map as follows: 1 goes to streaming, 2 to stopped, 3 to test-pattern and 4 to idle. The state port and register address 1 show the new state from the first rising edge after the write edge. Writes to address 1 have no effect.
- R3: Let S be the value of the settle register (address 2, read/write). A valid command written at address 0 reads back as its code until the (S+2)-th rising edge after the write edge. From that edge on it reads 0.
- R4: While the command register is non-zero, host writes to address 0 are ignored. The pending code and the state are unchanged.
- R5: A command code above 4 is cleared to 0 at the first edge after the write. It causes no state change, and it sets the error flag (cmd_error port, bit 0 of address 3).
- R6: Writing address 3 with bit 0 set clears the error flag. Writing it with bit 0 clear leaves the flag set.
- R7: Writing command code 0 changes neither the command register nor the state.
- R8: config_apply_en is high exactly while the state is stopped. It changes on the same edge as the state.
- R9: algo_update_en is high while the state is stopped or streaming and low in idle and test-pattern. It changes on the same edge as the state.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 command, 1 state, 2 settle, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| seq_state | output | 2 | Current sequencer state |
| config_apply_en | output | 1 | Configuration update enable |
| algo_update_en | output | 1 | Automatic-algorithm update enable |
| cmd_error | output | 1 | Sticky unknown-command flag |

## Verification
The hardest case to reach is a second host write that arrives while a command is still settling. With a short settle window that write would simply start a new command. The stimulus therefore sets a long settle count, issues a test-pattern command, and writes a stop code two edges later, inside the window. It then checks that the pending code, the state and the clear edge are all unchanged. Unknown codes are also sent to confirm that they clear on the first edge without moving the state, and that the error flag survives a write with bit 0 clear.

// File: rtl/seqc_pkg.sv
package seqc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STOPPED = 2'd1,
        ST_STREAM  = 2'd2,
        ST_TPAT    = 2'd3
    } seq_state_e;

    localparam int CODE_NONE    = 0;
    localparam int CODE_RUN     = 1;
    localparam int CODE_HALT    = 2;
    localparam int CODE_PATTERN = 3;
    localparam int CODE_PARK    = 4;

    localparam int ADDR_W      = 2;
    localparam logic [ADDR_W-1:0] A_CMD    = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_SETTLE = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

endpackage

// File: rtl/seqc_cmd_decode.sv
module seqc_cmd_decode
    import seqc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] code_i,
    output logic              known_o,
    output seq_state_e        target_o
);

    always_comb begin
        known_o  = 1'b1;
        target_o = ST_IDLE;
        if (code_i == DATA_W'(CODE_RUN)) begin
            target_o = ST_STREAM;
        end else if (code_i == DATA_W'(CODE_HALT)) begin
            target_o = ST_STOPPED;
        end else if (code_i == DATA_W'(CODE_PATTERN)) begin
            target_o = ST_TPAT;
        end else if (code_i == DATA_W'(CODE_PARK)) begin
            target_o = ST_IDLE;
        end else begin
            known_o = 1'b0;
        end
    end

endmodule

// File: rtl/seqc_settle_timer.sv
module seqc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             busy_o,
    output logic             expire_o
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = load_val_i;
        end else if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy_o   = t_q.busy;
    assign expire_o = t_q.busy && (t_q.cnt == '0);

    AST_TIMER_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !t_q.busy); // R4
    AST_TIMER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !load_i) |=> !t_q.busy); // R3

endmodule

// File: rtl/seqc_core.sv
module seqc_core
    import seqc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              err_clr_i,
    input  logic [CNT_W-1:0]  settle_i,
    output logic [DATA_W-1:0] cmd_o,
    output seq_state_e        state_o,
    output logic              cfg_en_o,
    output logic              algo_en_o,
    output logic              err_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        seq_state_e        st;
        logic              err;
        logic              cfg_en;
        logic              algo_en;
    } core_t;

    core_t r_d, r_q;

    logic       dec_known;
    seq_state_e dec_target;
    logic       tmr_busy, tmr_expire, tmr_load;
    logic       pending, accept;

    seqc_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .code_i   (r_q.cmd),
        .known_o  (dec_known),
        .target_o (dec_target)
    );

    seqc_settle_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (settle_i),
        .busy_o     (tmr_busy),
        .expire_o   (tmr_expire)
    );

    assign pending  = (r_q.cmd != '0);
    assign accept   = pending && !tmr_busy;
    assign tmr_load = accept && dec_known;

    always_comb begin
        r_d = r_q;
        if (cmd_wr_i && !pending) begin
            r_d.cmd = wdata_i;
        end
        if (err_clr_i) begin
            r_d.err = 1'b0;
        end
        if (accept) begin
            if (dec_known) begin
                r_d.st = dec_target;
            end else begin
                r_d.cmd = '0;
                r_d.err = 1'b1;
            end
        end
        if (tmr_expire) begin
            r_d.cmd = '0;
        end
        r_d.cfg_en  = (r_d.st == ST_STOPPED);
        r_d.algo_en = (r_d.st == ST_STOPPED) || (r_d.st == ST_STREAM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cmd     <= '0;
            r_q.st      <= ST_IDLE;
            r_q.err     <= 1'b0;
            r_q.cfg_en  <= 1'b0;
            r_q.algo_en <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o     = r_q.cmd;
    assign state_o   = r_q.st;
    assign cfg_en_o  = r_q.cfg_en;
    assign algo_en_o = r_q.algo_en;
    assign err_o     = r_q.err;

    AST_STATE_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_load |=> $stable(r_q.st)); // R2
    AST_CLEAR_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expire |=> (r_q.cmd == '0) && !tmr_busy); // R3
    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tmr_busy && !tmr_expire) |=> $stable(r_q.cmd)); // R4
    AST_UNKNOWN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dec_known) |=> (r_q.cmd == '0) && r_q.err && $stable(r_q.st)); // R5
    AST_CFG_ONLY_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cfg_en |-> (r_q.st == ST_STOPPED)); // R8
    AST_ALGO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) || (r_q.st == ST_TPAT)) |-> !r_q.algo_en); // R9

endmodule

// File: rtl/stream_seq_ctrl.sv
module stream_seq_ctrl
    import seqc_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SET_W        = 8,
    parameter int SETTLE_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [1:0]        seq_state,
    output logic              config_apply_en,
    output logic              algo_update_en,
    output logic              cmd_error
);

    localparam int ST_PAD  = DATA_W - 2;
    localparam int SET_PAD = DATA_W - SET_W;
    localparam int ERR_PAD = DATA_W - 1;

    typedef struct packed {
        logic [SET_W-1:0] settle;
    } host_t;

    host_t h_d, h_q;

    logic              cmd_wr, err_clr;
    logic [DATA_W-1:0] cmd_val;
    seq_state_e        st;

    assign cmd_wr  = reg_we && (reg_addr == A_CMD);
    assign err_clr = reg_we && (reg_addr == A_STATUS) && reg_wdata[0];

    always_comb begin
        h_d = h_q;
        if (reg_we && (reg_addr == A_SETTLE)) begin
            h_d.settle = reg_wdata[SET_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.settle <= SET_W'(SETTLE_RESET);
        end else begin
            h_q <= h_d;
        end
    end

    seqc_core #(.DATA_W(DATA_W), .CNT_W(SET_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr_i  (cmd_wr),
        .wdata_i   (reg_wdata),
        .err_clr_i (err_clr),
        .settle_i  (h_q.settle),
        .cmd_o     (cmd_val),
        .state_o   (st),
        .cfg_en_o  (config_apply_en),
        .algo_en_o (algo_update_en),
        .err_o     (cmd_error)
    );

    always_comb begin
        case (reg_addr)
            A_CMD:    reg_rdata = cmd_val;
            A_STATE:  reg_rdata = {{ST_PAD{1'b0}}, st};
            A_SETTLE: reg_rdata = {{SET_PAD{1'b0}}, h_q.settle};
            default:  reg_rdata = {{ERR_PAD{1'b0}}, cmd_error};
        endcase
    end

    assign seq_state = st;

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_error && err_clr && $stable(cmd_val)) |=> !cmd_error); // R6

endmodule

// File: tb/stream_seq_ctrl_test.sv
`timescale 1ns/1ps
module stream_seq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  seq_state;
    logic        config_apply_en, algo_update_en, cmd_error;

    always #2.5 clk = ~clk;

    stream_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_state(seq_state),
        .config_apply_en(config_apply_en), .algo_update_en(algo_update_en),
        .cmd_error(cmd_error)
    );

    typedef struct {
        int    cyc;
        int    sel;
        int    val;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(input int act, input int expv, input string tag);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic int observe(input int sel);
        case (sel)
            0:       return int'(reg_rdata);
            1:       return int'(seq_state);
            2:       return int'(config_apply_en);
            3:       return int'(algo_update_en);
            default: return int'(cmd_error);
        endcase
    endfunction

    // monitor: pops expectations due this cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].cyc == cyc) begin
                compare(observe(sbq[i].sel), sbq[i].val, sbq[i].tag);
                sbq.delete(i);
            end
        end
    end

    task automatic push(input int c, input int sel, input int v, input string tag);
        exp_t e;
        e.cyc = c; e.sel = sel; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic wr(input int a, input int d, output int w);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a[1:0]; reg_wdata = d[15:0];
        @(posedge clk); #1;
        w = cyc;
        reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(posedge clk);
        #1;
    endtask

    task automatic rd_check(input int a, input int expv, input string tag);
        @(posedge clk); #1;
        reg_addr = a[1:0];
        #1;
        compare(int'(reg_rdata), expv, tag);
        reg_addr = 2'd0;
    endtask

    // driver: issue a command and queue its expected trace
    task automatic send_cmd(input int code, input int s, input int old_st,
                            input int new_st, input bit known, output int w);
        wr(0, code, w);
        if (known) begin
            for (int k = 0; k <= s + 1; k++) push(w + k, 0, code, "R3");
            push(w + s + 2, 0, 0, "R3");
            push(w, 1, old_st, "R2");
            push(w + 1, 1, new_st, "R2");
            push(w + s + 2, 1, new_st, "R2");
            push(w + 1, 2, (new_st == 1) ? 1 : 0, "R8");
            push(w + 1, 3, (new_st == 1 || new_st == 2) ? 1 : 0, "R9");
        end else begin
            push(w, 0, code, "R5");
            push(w + 1, 0, 0, "R5");
            push(w + 1, 1, old_st, "R5");
            push(w + 2, 1, old_st, "R5");
            push(w + 1, 4, 1, "R5");
        end
    endtask

    initial begin
        int w, w2;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        compare(int'(seq_state), 0, "R1");
        compare(int'(config_apply_en), 0, "R1");
        compare(int'(algo_update_en), 0, "R1");
        compare(int'(cmd_error), 0, "R1");
        rd_check(0, 0, "R1");
        rd_check(1, 0, "R1");
        rd_check(2, 4, "R1");
        rd_check(3, 0, "R1");

        // halt with default settle 4
        send_cmd(2, 4, 0, 1, 1'b1, w);
        wait_until(w + 7);
        rd_check(1, 1, "R2");

        // settle 0, then run
        wr(2, 0, w);
        rd_check(2, 0, "R3");
        send_cmd(1, 0, 1, 2, 1'b1, w);
        wait_until(w + 3);

        // settle 7, test pattern, with a write landing mid-window
        wr(2, 7, w);
        send_cmd(3, 7, 2, 3, 1'b1, w);
        wr(0, 2, w2);
        push(w2 + 1, 0, 3, "R4");
        push(w + 9, 0, 0, "R4");
        push(w + 10, 1, 3, "R4");
        push(w + 10, 0, 0, "R4");
        wait_until(w + 11);

        // unknown code
        send_cmd(9, 7, 3, 3, 1'b0, w);
        wait_until(w + 3);
        rd_check(3, 1, "R5");
        compare(int'(algo_update_en), 0, "R9");

        // R6: bit0 clear keeps flag, bit0 set clears it
        wr(3, 0, w);
        push(w, 4, 1, "R6");
        wait_until(w + 1);
        wr(3, 1, w);
        push(w, 4, 0, "R6");
        wait_until(w + 1);
        rd_check(3, 0, "R6");

        // R7: NOP code
        wr(0, 0, w);
        push(w, 0, 0, "R7");
        push(w + 1, 0, 0, "R7");
        push(w + 1, 1, 3, "R7");
        push(w + 3, 1, 3, "R7");
        wait_until(w + 4);

        // R2: state register is read-only
        wr(1, 1, w);
        push(w, 1, 3, "R2");
        push(w + 1, 1, 3, "R2");
        wait_until(w + 2);

        // back to idle, then run and halt again
        send_cmd(4, 7, 3, 0, 1'b1, w);
        wait_until(w + 10);
        send_cmd(1, 7, 0, 2, 1'b1, w);
        wait_until(w + 10);
        compare(int'(config_apply_en), 0, "R8");
        send_cmd(2, 7, 2, 1, 1'b1, w);
        wait_until(w + 10);
        compare(int'(config_apply_en), 1, "R8");
        compare(int'(algo_update_en), 1, "R9");

        repeat (3) @(posedge clk);
        #1;
        if (sbq.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule